// File: doc/BRIEF.md
# Interrupt Status Aggregation Register

This block collects seven interrupt causes of a peripheral controller into one 8-bit status byte that a host reads, and it raises a single interrupt request line. Two causes are local events that this block latches itself: a timer expiry pulse and a watchdog expiry pulse. Four causes are summaries. Each one is the OR of a lower-level status vector that another unit owns: transceiver, HDLC link, monitor channel and command/indication change. The last cause is a frame-sync indication that counts only while its enable is set. The host uses it to align to the serial frame timing.

Clearing is mixed. A read of the status byte clears only the two latched local flags. A summary flag follows its source vector, so it falls only when the host reads and empties the lower-level register. The host always sees a flag as set on the read that clears it. An 8-bit mask selects which flags drive the request line. The mask does not change what a read returns. An accepted watchdog expiry also produces a host reset pulse of fixed length.

Top module: `isr_hub`

## Requirements
- R1: The status byte at address 3Ch has this bit layout: bit 7 frame sync, bit 6 command/indication change, bit 5 timer, bit 4 watchdog, bit 3 transceiver, bit 2 monitor, bit 1 HDLC link. Bit 0 always reads 0. A flag reads 1 when its cause is active.
- R2: After reset, the timer and watchdog flags are 0, the mask is FFh, the read data is 00h and the host reset output is 0.
- R3: A one-cycle timer event sets the timer flag. The flag stays set through any number of idle cycles until a read of address 3Ch.
- R4: A read of address 3Ch returns the flags as they were before that read, and it clears the timer and watchdog flags. If a new event arrives in the same cycle as that read, the flag stays set.
- R5: A watchdog event sets the watchdog flag only while the terminal-mode input is 1. Otherwise the event is ignored.
- R6: An accepted watchdog event drives the host reset output high for RST_LEN cycles (default 4), starting in the cycle after the event. Another accepted event restarts the count.
- R7: Each of the transceiver, HDLC, monitor and command/indication flags equals the OR of its source vector. A read of 3Ch does not change any of them.
- R8: The frame-sync flag equals the sync event input ANDed with the sync enable input.
- R9: The interrupt request is 1 exactly when some status flag and its mask bit at the same position are both 1. The mask does not alter the status byte as read.
- R10: A write to address 3Dh loads the mask, and a read of 3Dh returns it. A read of any other address returns 00h and clears no flag.
- R11: Read data appears on the read data port in the cycle after the read strobe. It holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW (8) | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| tmr_evt | input | 1 | Timer expiry pulse |
| wdog_evt | input | 1 | Watchdog expiry pulse |
| term_mode | input | 1 | Terminal-function mode, gates the watchdog flag |
| sync_evt | input | 1 | Frame-sync indication level |
| sync_en | input | 1 | Frame-sync interrupt enable |
| ci_stat | input | CI_W (2) | Command/indication change status vector |
| xcvr_stat | input | XCVR_W (4) | Transceiver status vector |
| mon_stat | input | MON_W (2) | Monitor channel status vector |
| link_stat | input | LINK_W (6) | HDLC link status vector |
| irq_o | output | 1 | Masked interrupt request |
| host_rst_o | output | 1 | Host reset pulse after watchdog expiry |

## Verification
The assertions take for granted that the timer and watchdog inputs are single-cycle pulses sampled on the clock and that a read strobe lasts one cycle per access. They also assume that a summary vector changes only when its owning unit changes it. The stimulus drives every input on the falling edge and keeps each strobe high for exactly one cycle. It places events in the same cycle as clearing reads only on purpose, so those coincidences are checked against the reference model as well.

// File: rtl/isr_pkg.sv
package isr_pkg;
  localparam int BIT_SYNC = 7;
  localparam int BIT_CI   = 6;
  localparam int BIT_TMR  = 5;
  localparam int BIT_WDOG = 4;
  localparam int BIT_XCVR = 3;
  localparam int BIT_MON  = 2;
  localparam int BIT_LINK = 1;

  localparam int N_LOCAL  = 2;
  localparam int LOC_TMR  = 0;
  localparam int LOC_WDOG = 1;

  function automatic logic [7:0] pack_status(
    input logic sync_f, input logic ci_f, input logic tmr_f, input logic wdog_f,
    input logic xcvr_f, input logic mon_f, input logic link_f);
    logic [7:0] s;
    s = 8'h00;
    s[BIT_SYNC] = sync_f;
    s[BIT_CI]   = ci_f;
    s[BIT_TMR]  = tmr_f;
    s[BIT_WDOG] = wdog_f;
    s[BIT_XCVR] = xcvr_f;
    s[BIT_MON]  = mon_f;
    s[BIT_LINK] = link_f;
    return s;
  endfunction

  function automatic logic masked_any(input logic [7:0] stat, input logic [7:0] msk);
    return |(stat & msk);
  endfunction
endpackage

// File: rtl/isr_summary.sv
module isr_summary #(
  parameter int W = 4
) (
  input  logic [W-1:0] src,
  output logic         sum_o
);
  always_comb sum_o = |src;
endmodule

// File: rtl/isr_sticky.sv
module isr_sticky (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !clr_i) |=> flag_o); // R3
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R4
  AST_CLR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !flag_o); // R4
endmodule

// File: rtl/isr_rst_pulse.sv
module isr_rst_pulse #(
  parameter int LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic pulse_o
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt_q <= '0;
    else if (trig_i)       cnt_q <= CW'(LEN);
    else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  always_comb pulse_o = (cnt_q != '0);

  AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> pulse_o); // R6
  AST_PULSE_END: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && !pulse_o) |=> !pulse_o); // R6
endmodule

// File: rtl/isr_hub.sv
module isr_hub #(
  parameter int         AW        = 8,
  parameter logic [7:0] STAT_ADDR = 8'h3C,
  parameter logic [7:0] MASK_ADDR = 8'h3D,
  parameter int         CI_W      = 2,
  parameter int         XCVR_W    = 4,
  parameter int         MON_W     = 2,
  parameter int         LINK_W    = 6,
  parameter int         RST_LEN   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [AW-1:0]     bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic              tmr_evt,
  input  logic              wdog_evt,
  input  logic              term_mode,
  input  logic              sync_evt,
  input  logic              sync_en,
  input  logic [CI_W-1:0]   ci_stat,
  input  logic [XCVR_W-1:0] xcvr_stat,
  input  logic [MON_W-1:0]  mon_stat,
  input  logic [LINK_W-1:0] link_stat,
  output logic              irq_o,
  output logic              host_rst_o
);
  import isr_pkg::*;

  localparam logic [AW-1:0] A_STAT = AW'(STAT_ADDR);
  localparam logic [AW-1:0] A_MASK = AW'(MASK_ADDR);

  // named internal events
  logic stat_rd, mask_wr, mask_rd, tmr_set, wdog_set;
  logic ci_f, xcvr_f, mon_f, link_f, sync_f;
  logic [N_LOCAL-1:0] loc_set, loc_flag;
  logic [7:0] status_w, mask_q;

  always_comb begin
    stat_rd  = bus_rd && (bus_addr == A_STAT);
    mask_rd  = bus_rd && (bus_addr == A_MASK);
    mask_wr  = bus_wr && (bus_addr == A_MASK);
    tmr_set  = tmr_evt;
    wdog_set = wdog_evt && term_mode;
    sync_f   = sync_evt && sync_en;
    loc_set[LOC_TMR]  = tmr_set;
    loc_set[LOC_WDOG] = wdog_set;
  end

  genvar g;
  generate
    for (g = 0; g < N_LOCAL; g++) begin : g_local
      isr_sticky u_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (loc_set[g]),
        .clr_i (stat_rd),
        .flag_o(loc_flag[g])
      );
    end
  endgenerate

  isr_summary #(.W(CI_W))   u_sum_ci   (.src(ci_stat),   .sum_o(ci_f));
  isr_summary #(.W(XCVR_W)) u_sum_xcvr (.src(xcvr_stat), .sum_o(xcvr_f));
  isr_summary #(.W(MON_W))  u_sum_mon  (.src(mon_stat),  .sum_o(mon_f));
  isr_summary #(.W(LINK_W)) u_sum_link (.src(link_stat), .sum_o(link_f));

  isr_rst_pulse #(.LEN(RST_LEN)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .trig_i (wdog_set),
    .pulse_o(host_rst_o)
  );

  always_comb status_w = pack_status(sync_f, ci_f, loc_flag[LOC_TMR], loc_flag[LOC_WDOG],
                                     xcvr_f, mon_f, link_f);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= 8'hFF;
    else if (mask_wr) mask_q <= bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bus_rdata <= 8'h00;
    else if (stat_rd) bus_rdata <= status_w;
    else if (mask_rd) bus_rdata <= mask_q;
    else if (bus_rd)  bus_rdata <= 8'h00;
  end

  always_comb irq_o = masked_any(status_w, mask_q);

  AST_RD_SEES_TMR: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && loc_flag[LOC_TMR]) |=> bus_rdata[BIT_TMR]); // R4
  AST_WDOG_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!term_mode && !loc_flag[LOC_WDOG] && !stat_rd) |=> !loc_flag[LOC_WDOG]); // R5
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> $stable(bus_rdata)); // R11
  AST_BIT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd |=> !bus_rdata[0]); // R1
endmodule

// File: tb/test_isr_hub.sv
module test_isr_hub;
  localparam int RLEN = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] addr = 8'h00;
  logic rd = 1'b0, wr = 1'b0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rdata;
  logic tmr = 1'b0, wdg = 1'b0, tmode = 1'b0, sev = 1'b0, sen = 1'b0;
  logic [1:0] ci = '0;
  logic [3:0] xc = '0;
  logic [1:0] mon = '0;
  logic [5:0] lk = '0;
  logic irq, hrst;

  int total = 0, bad = 0;
  bit done = 0;

  // reference model state
  int m_tin = 0, m_wov = 0, m_mask = 255, m_rdata = 0, m_cnt = 0;

  always #10 clk = ~clk;

  isr_hub i_isr_hub (
    .clk(clk), .rst_n(rst_n), .bus_addr(addr), .bus_rd(rd), .bus_wr(wr),
    .bus_wdata(wdata), .bus_rdata(rdata), .tmr_evt(tmr), .wdog_evt(wdg),
    .term_mode(tmode), .sync_evt(sev), .sync_en(sen), .ci_stat(ci),
    .xcvr_stat(xc), .mon_stat(mon), .link_stat(lk), .irq_o(irq), .host_rst_o(hrst));

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int model_stat();
    int s = 0;
    if (sev && sen)  s += 128;
    if (ci != 0)     s += 64;
    if (m_tin != 0)  s += 32;
    if (m_wov != 0)  s += 16;
    if (xc != 0)     s += 8;
    if (mon != 0)    s += 4;
    if (lk != 0)     s += 2;
    return s;
  endfunction

  // one clock: model next state, edge, compare at falling edge
  task automatic tick();
    int st, n_rd, n_tin, n_wov, n_mask, n_cnt;
    bit acc;
    st = model_stat();
    n_rd = m_rdata;
    if (rd) n_rd = (addr == 8'h3C) ? st : (addr == 8'h3D) ? m_mask : 0;
    acc = wdg && tmode;
    n_tin = tmr ? 1 : ((rd && addr == 8'h3C) ? 0 : m_tin);
    n_wov = acc ? 1 : ((rd && addr == 8'h3C) ? 0 : m_wov);
    n_mask = (wr && addr == 8'h3D) ? int'(wdata) : m_mask;
    n_cnt = acc ? RLEN : (m_cnt > 0 ? m_cnt - 1 : 0);
    @(posedge clk);
    m_rdata = n_rd; m_tin = n_tin; m_wov = n_wov; m_mask = n_mask; m_cnt = n_cnt;
    @(negedge clk);
    chk("R11 rdata", rdata, m_rdata);
    chk("R9 irq", irq, ((model_stat() & m_mask) != 0) ? 1 : 0);
    chk("R6 host_rst", hrst, (m_cnt != 0) ? 1 : 0);
    tmr = 0; wdg = 0; rd = 0; wr = 0;
  endtask

  task automatic read_exp(input logic [7:0] a, input int exp, input string tag);
    addr = a; rd = 1;
    tick();
    chk(tag, rdata, exp);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 rdata reset", rdata, 0);
    chk("R2 host_rst reset", hrst, 0);
    chk("R2 irq reset", irq, 0);
    rst_n = 1;
    @(negedge clk);
    read_exp(8'h3D, 8'hFF, "R2 mask reset");
    read_exp(8'h3C, 8'h00, "R2 flags reset");

    // R3 sticky timer, R1 position
    tmr = 1; tick();
    idle(5);
    read_exp(8'h3C, 8'h20, "R3 R1 timer bit5");
    read_exp(8'h3C, 8'h00, "R4 timer cleared");

    // R4 event coincident with clearing read
    tmr = 1; tick();
    tmr = 1; read_exp(8'h3C, 8'h20, "R4 read sees set");
    read_exp(8'h3C, 8'h20, "R4 coincident set kept");
    read_exp(8'h3C, 8'h00, "R4 cleared after");

    // R5 watchdog gated
    tmode = 0; wdg = 1; tick();
    chk("R5 no reset pulse", hrst, 0);
    read_exp(8'h3C, 8'h00, "R5 ignored when mode off");
    tmode = 1; wdg = 1; tick();
    chk("R6 pulse starts", hrst, 1);
    idle(2);
    wdg = 1; tick();          // R6 restart
    idle(RLEN - 1);
    chk("R6 pulse still high", hrst, 1);
    tick();
    chk("R6 pulse ended", hrst, 0);
    read_exp(8'h3C, 8'h10, "R5 R1 watchdog bit4");
    read_exp(8'h3C, 8'h00, "R4 watchdog cleared");

    // R7 summaries
    xc = 4'b0100; tick();
    read_exp(8'h3C, 8'h08, "R7 R1 xcvr bit3");
    read_exp(8'h3C, 8'h08, "R7 xcvr not cleared by read");
    xc = 0; mon = 2'b10; tick();
    read_exp(8'h3C, 8'h04, "R7 R1 monitor bit2");
    mon = 0; lk = 6'b100000; tick();
    read_exp(8'h3C, 8'h02, "R7 R1 link bit1");
    lk = 0; ci = 2'b01; tick();
    read_exp(8'h3C, 8'h40, "R7 R1 ci bit6");
    ci = 0; tick();

    // R8 sync
    sev = 1; sen = 0; tick();
    read_exp(8'h3C, 8'h00, "R8 sync disabled");
    sen = 1; tick();
    read_exp(8'h3C, 8'h80, "R8 R1 sync bit7");
    sev = 0; sen = 0; tick();

    // R9, R10 mask
    addr = 8'h3D; wdata = 8'h00; wr = 1; tick();
    read_exp(8'h3D, 8'h00, "R10 mask readback");
    tmr = 1; tick();
    chk("R9 masked irq low", irq, 0);
    addr = 8'h3D; wdata = 8'h20; wr = 1; tick();
    chk("R9 unmasked irq high", irq, 1);
    read_exp(8'h10, 8'h00, "R10 other address zero");
    chk("R10 other read keeps flag", irq, 1);
    addr = 8'h3D; wdata = 8'hDF; wr = 1; tick();
    read_exp(8'h3C, 8'h20, "R9 mask does not alter read");

    // mixed stimulus against the model
    addr = 8'h3D; wdata = 8'hFF; wr = 1; tick();
    for (int i = 0; i < 400; i++) begin
      tmr = ($urandom_range(0, 7) == 0);
      wdg = ($urandom_range(0, 15) == 0);
      tmode = $urandom_range(0, 1);
      sev = $urandom_range(0, 1); sen = $urandom_range(0, 1);
      if ($urandom_range(0, 5) == 0) xc = 4'($urandom_range(0, 15));
      if ($urandom_range(0, 5) == 0) ci = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0) mon = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 5) == 0) lk = 6'($urandom_range(0, 63));
      rd = ($urandom_range(0, 2) == 0);
      wr = ($urandom_range(0, 9) == 0);
      case ($urandom_range(0, 3))
        0, 1: addr = 8'h3C;
        2: addr = 8'h3D;
        default: addr = 8'($urandom_range(0, 255));
      endcase
      wdata = 8'($urandom_range(0, 255));
      tick();
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule